// File: doc/BRIEF.md
# Completion Descriptor Stream Serializer

This block sends a completion descriptor that carries no data payload out on an AXI4-Stream master port. The descriptor is three 32-bit Dwords (96 bits) with Dword 0 in the least significant bits. It comes in through a valid/ready handshake and is held in an internal register. The serializer then cuts it into beats of `DATA_W` bits, where `DATA_W` is 64, 128 or 256. For each beat it drives data, a per-Dword keep mask, an end-of-packet flag and a start-of-frame flag. Downstream backpressure is honoured on every beat.

A controller state machine with three named states drives the block:

- **ST_IDLE** means no packet is being shown. Its transitions are *accept* (to ST_FIRST_BEAT) and *stay idle*.
- **ST_FIRST_BEAT** shows beat 0. Its transitions are:
  - *hold*, while tready is low;
  - *advance*, to ST_SECOND_BEAT, at 64 bits only;
  - *reload*, to ST_FIRST_BEAT, when a new descriptor waits at the final beat;
  - *drain*, to ST_IDLE.
- **ST_SECOND_BEAT** shows beat 1 at 64 bits. Its transitions are *hold*, *reload* and *drain*.

A new descriptor can be taken in the same cycle that the final beat is accepted. Packets can therefore follow each other with no idle cycle between them.

Top module: `cpl_desc_ser`

## Requirements
- R1: A packet takes exactly two beats when DATA_W is 64 and exactly one beat when DATA_W is 128 or 256.
- R2: Once the first beat of a packet is shown, m_tvalid stays high on every cycle until the final beat is accepted.
- R3: While m_tvalid is high and m_tready is low, m_tdata, m_tkeep, m_tlast and m_tsof keep their values into the next cycle.
- R4: Dword n of the descriptor appears in Dword lane (n mod LANES) of beat (n div LANES), where LANES = DATA_W/32 and lane 0 is bits 31:0. Lanes beyond Dword 2 are driven to zero.
- R5: m_tkeep has one bit per Dword lane, and its set bits run contiguously from lane 0. The values are 2'b11 then 2'b01 at 64 bits, 4'b0111 at 128 bits and 8'b00000111 at 256 bits.
- R6: m_tlast is high on the final beat of each packet and low on every other beat. Every beat before the final one has all m_tkeep bits set.
- R7: m_tsof is high on the first beat of each packet and low on every other beat.
- R8: desc_ready is high when the block is idle, or when the final beat is shown with m_tready high. Otherwise desc_ready is low, and desc_data has no effect on the beats being shown.
- R9: If a descriptor is offered while the final beat is accepted, the first beat of the next packet is shown on the next cycle.
- R10: The synchronous active-high reset drops m_tvalid and raises desc_ready. The first packet after reset starts at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_data | input | 96 | Descriptor, Dword 0 in bits 31:0 |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Downstream accepts beat |
| m_tdata | output | DATA_W | Beat data |
| m_tkeep | output | DATA_W/32 | Per-Dword valid mask |
| m_tlast | output | 1 | Final beat of packet |
| m_tsof | output | 1 | Start-of-frame user flag, first beat |

## Verification
A wrong controller state shows up at the ports on the same cycle, because every output decodes the state register directly. A state that is stuck or skipped gives a wrong beat count, which shows as m_tlast or m_tsof on the wrong beat or m_tvalid dropping inside a packet. A wrong beat index gives the wrong Dwords in m_tdata and the wrong m_tkeep pattern. A descriptor register that reloads while busy shows at once on a stalled beat as changed data. The directed stalls, back-to-back sends and a mid-packet reset provoke each of these, and all three widths run side by side.

// File: rtl/cpl_ser_pkg.sv
package cpl_ser_pkg;

    localparam int DESC_DWORDS = 3;
    localparam int DESC_W      = DESC_DWORDS * 32;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_FIRST_BEAT  = 2'd1,
        ST_SECOND_BEAT = 2'd2
    } ser_state_e;

endpackage

// File: rtl/cpl_ser_ctrl.sv
module cpl_ser_ctrl
    import cpl_ser_pkg::*;
#(
    parameter int NBEATS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       desc_valid,
    input  logic       beat_ready,
    output ser_state_e state,
    output logic       desc_ready,
    output logic       load,
    output logic       final_beat
);

    ser_state_e state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Outputs and next state
    always_comb begin
        final_beat = 1'b0;
        state_nx   = state;
        unique case (state)
            ST_IDLE: begin
                if (desc_valid) state_nx = ST_FIRST_BEAT;   // accept
            end
            ST_FIRST_BEAT: begin
                final_beat = (NBEATS == 1);
                if (beat_ready) begin
                    if (NBEATS > 1)      state_nx = ST_SECOND_BEAT; // advance
                    else if (desc_valid) state_nx = ST_FIRST_BEAT;  // reload
                    else                 state_nx = ST_IDLE;        // drain
                end
            end
            ST_SECOND_BEAT: begin
                final_beat = 1'b1;
                if (beat_ready) begin
                    if (desc_valid) state_nx = ST_FIRST_BEAT;       // reload
                    else            state_nx = ST_IDLE;             // drain
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        desc_ready = (state == ST_IDLE) || (final_beat && beat_ready);
        load       = desc_valid && desc_ready;
    end

    assert_second_follows_first_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SECOND_BEAT) |-> ($past(state) == ST_FIRST_BEAT || $past(state) == ST_SECOND_BEAT));

    assert_no_second_wide_R1: assert property (@(posedge clk) disable iff (rst)
        (NBEATS == 1) |-> (state != ST_SECOND_BEAT));

endmodule

// File: rtl/cpl_desc_hold.sv
module cpl_desc_hold
    import cpl_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DESC_W-1:0] din,
    output logic [DESC_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (load) dout <= din;
    end

endmodule

// File: rtl/cpl_beat_fmt.sv
module cpl_beat_fmt
    import cpl_ser_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DESC_W-1:0]      desc,
    input  logic                   beat_idx,
    output logic [DATA_W-1:0]      tdata,
    output logic [DATA_W/32-1:0]   tkeep
);

    localparam int LANES = DATA_W / 32;
    localparam int PAD_W = 2 * DATA_W;

    logic [PAD_W-1:0] padded;

    always_comb begin
        padded = '0;
        padded[DESC_W-1:0] = desc;
        tdata = padded[beat_idx*DATA_W +: DATA_W];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic K_FIRST  = (i < DESC_DWORDS);
        localparam logic K_SECOND = ((LANES + i) < DESC_DWORDS);
        assign tkeep[i] = beat_idx ? K_SECOND : K_FIRST;
    end

endmodule

// File: rtl/cpl_desc_ser.sv
module cpl_desc_ser
    import cpl_ser_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 desc_valid,
    output logic                 desc_ready,
    input  logic [95:0]          desc_data,
    output logic                 m_tvalid,
    input  logic                 m_tready,
    output logic [DATA_W-1:0]    m_tdata,
    output logic [DATA_W/32-1:0] m_tkeep,
    output logic                 m_tlast,
    output logic                 m_tsof
);

    localparam int LANES  = DATA_W / 32;
    localparam int NBEATS = (DESC_W + DATA_W - 1) / DATA_W;

    ser_state_e        state;
    logic              load;
    logic              final_beat;
    logic [DESC_W-1:0] held;

    cpl_ser_ctrl #(.NBEATS(NBEATS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .desc_valid (desc_valid),
        .beat_ready (m_tready),
        .state      (state),
        .desc_ready (desc_ready),
        .load       (load),
        .final_beat (final_beat)
    );

    cpl_desc_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .din  (desc_data),
        .dout (held)
    );

    cpl_beat_fmt #(.DATA_W(DATA_W)) u_fmt (
        .desc     (held),
        .beat_idx (state == ST_SECOND_BEAT),
        .tdata    (m_tdata),
        .tkeep    (m_tkeep)
    );

    always_comb begin
        m_tvalid = (state != ST_IDLE);
        m_tlast  = final_beat;
        m_tsof   = (state == ST_FIRST_BEAT);
    end

    assert_no_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tlast) |=> m_tvalid);

    assert_stall_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                     && $stable(m_tlast) && $stable(m_tsof)));

    assert_keep_contig_R5: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tkeep[0] && ((m_tkeep & (m_tkeep + {{(LANES-1){1'b0}}, 1'b1})) == '0)));

    assert_keep_full_R6: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tlast) |-> (&m_tkeep));

    assert_sof_next_R7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast) |=> (!m_tvalid || m_tsof));

    assert_sof_mid_R7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && !m_tlast) |=> !m_tsof);

    assert_ready_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (desc_ready && m_tvalid) |-> (m_tready && m_tlast));

    assert_b2b_R9: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready) |=> (m_tvalid && m_tsof));

endmodule

// File: tb/cpl_desc_ser_tb_top.sv
module cpl_desc_ser_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         dv  [3];
    logic         dr  [3];
    logic [95:0]  dd  [3];
    logic         tv  [3];
    logic         rdy [3];
    logic [255:0] td  [3];
    logic [7:0]   kp  [3];
    logic         tl  [3];
    logic         sf  [3];

    int n_chk  = 0;
    int n_fail = 0;

    for (genvar k = 0; k < 3; k++) begin : g_w
        localparam int W = 64 << k;
        cpl_desc_ser #(.DATA_W(W)) dut_i (
            .clk        (clk),
            .rst        (rst),
            .desc_valid (dv[k]),
            .desc_ready (dr[k]),
            .desc_data  (dd[k]),
            .m_tvalid   (tv[k]),
            .m_tready   (rdy[k]),
            .m_tdata    (td[k][W-1:0]),
            .m_tkeep    (kp[k][W/32-1:0]),
            .m_tlast    (tl[k]),
            .m_tsof     (sf[k])
        );
    end

    function automatic int nb(int k);
        return (k == 0) ? 2 : 1;
    endfunction

    function automatic logic [255:0] dmask(int k);
        return (k == 2) ? {256{1'b1}} : ((256'd1 << (64 << k)) - 256'd1);
    endfunction

    function automatic logic [7:0] kmask(int k);
        return 8'((9'd1 << (2 << k)) - 9'd1);
    endfunction

    function automatic logic [255:0] exp_data(int k, logic [95:0] d, int b);
        logic [511:0] p;
        p = {416'd0, d};
        p = p >> (b * (64 << k));
        return p[255:0] & dmask(k);
    endfunction

    function automatic logic [7:0] exp_keep(int k, int b);
        logic [7:0] r;
        int l;
        l = 2 << k;
        r = '0;
        for (int i = 0; i < 8; i++)
            r[i] = (i < l) && ((b * l + i) < 3);
        return r;
    endfunction

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_beat(int k, logic [95:0] d, int b, string tag);
        chk({tag, " R2 tvalid"}, 256'(tv[k]), 256'(1));
        chk({tag, " R4 tdata"}, td[k] & dmask(k), exp_data(k, d, b));
        chk({tag, " R5 tkeep"}, 256'(kp[k] & kmask(k)), 256'(exp_keep(k, b)));
        chk({tag, " R6 tlast"}, 256'(tl[k]), 256'(b == nb(k) - 1));
        chk({tag, " R7 tsof"}, 256'(sf[k]), 256'(b == 0));
    endtask

    // Offer d, then walk every beat with 'stall' held cycles per beat.
    task automatic send_pkt(int k, logic [95:0] d, int stall);
        @(negedge clk);
        dv[k] = 1'b1; dd[k] = d; rdy[k] = 1'b1;
        #1 chk("R8 ready when idle", 256'(dr[k]), 256'(1));
        @(negedge clk);
        dv[k] = 1'b0;
        for (int b = 0; b < nb(k); b++) begin
            rdy[k] = 1'b0;
            for (int s = 0; s < stall; s++) begin
                dd[k] = ~d ^ 96'(s);
                #1 check_beat(k, d, b, "R3 R8 stalled");
                chk("R8 ready while busy", 256'(dr[k]), 256'(0));
                @(negedge clk);
            end
            rdy[k] = 1'b1;
            #1 check_beat(k, d, b, "R1 beat");
            chk("R8 ready at release", 256'(dr[k]), 256'(b == nb(k) - 1));
            @(negedge clk);
        end
        #1 chk("R1 idle after final beat", 256'(tv[k]), 256'(0));
    endtask

    task automatic t_reset_state();
        for (int k = 0; k < 3; k++) begin
            chk("R10 tvalid low in reset", 256'(tv[k]), 256'(0));
            chk("R10 ready high after reset", 256'(dr[k]), 256'(1));
        end
    endtask

    task automatic t_back_to_back(int k, logic [95:0] a, logic [95:0] b2);
        @(negedge clk);
        dv[k] = 1'b1; dd[k] = a; rdy[k] = 1'b1;
        @(negedge clk);
        dv[k] = 1'b0;
        for (int b = 0; b < nb(k); b++) begin
            if (b == nb(k) - 1) begin
                dv[k] = 1'b1; dd[k] = b2;
                #1 chk("R9 ready at final beat", 256'(dr[k]), 256'(1));
            end
            #1 check_beat(k, a, b, "R9 first pkt");
            @(negedge clk);
        end
        dv[k] = 1'b0;
        for (int b = 0; b < nb(k); b++) begin
            #1 check_beat(k, b2, b, "R9 next pkt");
            @(negedge clk);
        end
        #1 chk("R9 idle after pair", 256'(tv[k]), 256'(0));
    endtask

    task automatic t_reset_mid(int k, logic [95:0] d);
        @(negedge clk);
        dv[k] = 1'b1; dd[k] = d; rdy[k] = 1'b0;
        @(negedge clk);
        dv[k] = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 chk("R10 tvalid cleared", 256'(tv[k]), 256'(0));
        chk("R10 ready restored", 256'(dr[k]), 256'(1));
        send_pkt(k, ~d, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            dv[k] = 1'b0; dd[k] = '0; rdy[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        #1 t_reset_state();
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            send_pkt(k, {32'hC0DE0002, 32'hB0B00001, 32'hA0A00000}, 0);
            send_pkt(k, {32'h33333333, 32'h22222222, 32'h11111111}, 3);
            send_pkt(k, {32'hFFFFFFFF, 32'h00000000, 32'h80000001}, 1);
            t_back_to_back(k, {32'h0000AA02, 32'h0000AA01, 32'h0000AA00},
                              {32'h0000BB02, 32'h0000BB01, 32'h0000BB00});
            t_reset_mid(k, {32'h5A5A5A5A, 32'hA5A5A5A5, 32'h12345678});
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule